// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the protection state of a serial flash status byte. That state is a write-enable latch, a three-bit guard code, an anchor bit that picks the end of the array where the guarded region sits, and a lock bit. Together with an active-low write-protect pin, the lock bit can freeze the protection configuration. The command decoder upstream sends one-cycle requests: set the write-enable latch, write the status byte, or start a program or erase at a 24-bit address. The block answers with a registered reject flag for refused status writes and a registered grant pulse for program or erase requests that may proceed.

The array is 4 MiB and is divided into 64 sectors of 64 KiB each. A guard code of zero protects nothing. A nonzero code n protects 2^(n-1) whole sectors, counted from the top of the array or from the bottom depending on the anchor bit. A combinational flag tells at all times whether the address presented is inside the guarded region. The non-volatile storage that would hold these bits is replaced here by reset defaults.

Top module: `flash_guard`

## Requirements
- R1: After synchronous reset every status bit (lock, anchor, guard code, write-enable latch) is 0, and the reject and grant outputs are low.
- R2: The status byte has lock in bit 7, anchor in bit 5, guard code bits 2..0 in bits 4..2, the write-enable latch in bit 1, and 0 in bits 6 and 0. A status write takes its new values from the same bit positions of its data.
- R3: A write-enable request sets the latch in the next cycle. When a status-write or program/erase request arrives in the same cycle, the write-enable request has no effect.
- R4: A status write made while the latch is 1 and the hardware lock is not active loads lock, anchor and guard code in the next cycle and clears the latch.
- R5: The hardware lock is active exactly when the lock bit is 1 and the write-protect pin is 0. While it is active, every status write is refused and the anchor and guard code cannot change.
- R6: A status write made while the latch is 0 is refused.
- R7: A refused status write raises the reject output for exactly the next cycle. It leaves all status bits and the latch unchanged, unless a program/erase request in the same cycle clears the latch.
- R8: Guard code 0 protects no address. A nonzero code n protects 2^(n-1) sectors, where the sector index is address bits 21..16 and address bits 23..22 are ignored.
- R9: With the anchor at 0 the guarded sectors are the highest-numbered ones. With the anchor at 1 they are the lowest-numbered ones.
- R10: The address-protected output follows the presented address and the current status bits in the same cycle, with no clock edge in between.
- R11: A program/erase request gives a grant pulse in the next cycle only if the latch was 1 and the address was outside the guarded region. Every such request clears the latch, whether it is granted or blocked.
- R12: With the write-protect pin at 1, status writes are accepted even when the lock bit is 1, so the lock bit itself can be cleared.
- R13: When a status write and a program/erase request arrive in the same cycle, the program/erase request is judged against the status bits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set_req | input | 1 | Request to set the write-enable latch |
| wrsr_req | input | 1 | Status-write request |
| wrsr_data | input | 8 | New status byte (layout per R2) |
| pe_req | input | 1 | Program/erase request |
| pe_addr | input | 24 | Byte address checked for protection |
| addr_protected | output | 1 | pe_addr lies in the guarded region |
| status_rd | output | 8 | Status byte readback |
| wrsr_reject | output | 1 | One-cycle pulse for a refused status write |
| pe_grant | output | 1 | One-cycle pulse for an allowed program/erase |

## Verification
A status write and a program/erase request can arrive in the same cycle. Both compete for the single write-enable latch, and the program/erase request can land on a region that the status write is about to move. The bench raises both requests on the same edge twice. First the whole array is guarded and the write clears the guard. Then nothing is guarded and the write guards the whole array. The grant must follow the guard that was in force before the edge, the new status bits must appear, and the latch must end at 0. The bench also raises a write-enable request together with a status write and checks that the latch keeps its previous value.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    localparam int ADDR_W    = 24;
    localparam int ARRAY_AW  = 22;
    localparam int SECT_AW   = 16;
    localparam int GUARD_W   = 3;
    localparam int STAT_W    = 8;

    // status byte bit positions
    localparam int ST_LOCK   = 7;
    localparam int ST_ANCHOR = 5;
    localparam int ST_GLO    = 2;
    localparam int ST_WEL    = 1;

    typedef struct packed {
        logic               lock;
        logic               anchor;
        logic [GUARD_W-1:0] guard;
    } prot_cfg_t;

    function automatic int unsigned guard_sectors(input logic [GUARD_W-1:0] code,
                                                  input int unsigned num_sect);
        int unsigned n;
        if (code == '0) begin
            n = 0;
        end else begin
            n = 32'd1 << (int'(code) - 1);
            if (n > num_sect) n = num_sect;
        end
        return n;
    endfunction

    function automatic prot_cfg_t cfg_from_byte(input logic [STAT_W-1:0] b);
        prot_cfg_t c;
        c.lock   = b[ST_LOCK];
        c.anchor = b[ST_ANCHOR];
        c.guard  = b[ST_GLO +: GUARD_W];
        return c;
    endfunction

    function automatic logic [STAT_W-1:0] byte_from_cfg(input prot_cfg_t c, input logic wel);
        logic [STAT_W-1:0] b;
        b = '0;
        b[ST_LOCK]             = c.lock;
        b[ST_ANCHOR]           = c.anchor;
        b[ST_GLO +: GUARD_W]   = c.guard;
        b[ST_WEL]              = wel;
        return b;
    endfunction

endpackage

// File: rtl/prot_range_decode.sv
module prot_range_decode
    import flash_prot_pkg::*;
#(
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_ARRAY_AW = ARRAY_AW,
    parameter int P_SECT_AW  = SECT_AW
) (
    input  logic [P_ADDR_W-1:0] addr,
    input  prot_cfg_t           cfg,
    output logic                hit
);
    localparam int IDX_W    = P_ARRAY_AW - P_SECT_AW;
    localparam int NUM_SECT = 1 << IDX_W;
    localparam logic [IDX_W:0] NS_V = (IDX_W+1)'(NUM_SECT);

    logic [IDX_W:0] cnt;
    logic [IDX_W:0] idx;
    logic [IDX_W:0] top_start;

    always_comb begin
        cnt       = (IDX_W+1)'(guard_sectors(cfg.guard, NUM_SECT));
        idx       = {1'b0, addr[P_ARRAY_AW-1:P_SECT_AW]};
        top_start = NS_V - cnt;
        if (cfg.anchor) hit = (idx < cnt);
        else            hit = (idx >= top_start);
    end
endmodule

// File: rtl/prot_status_ctrl.sv
module prot_status_ctrl
    import flash_prot_pkg::*;
#(
    parameter int P_STAT_W = STAT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wp_n,
    input  logic                wel_set_req,
    input  logic                wrsr_req,
    input  logic [P_STAT_W-1:0] wrsr_data,
    input  logic                pe_req,
    input  logic                pe_hit,
    output prot_cfg_t           cfg,
    output logic                wel,
    output logic                wrsr_reject,
    output logic                pe_grant
);
    logic hw_locked;
    logic wr_ok;
    logic wr_bad;
    logic wel_clear;
    logic wel_set_ok;

    always_comb begin
        hw_locked  = cfg.lock & ~wp_n;
        wr_ok      = wrsr_req & wel & ~hw_locked;
        wr_bad     = wrsr_req & ~wr_ok;
        wel_clear  = wr_ok | pe_req;
        wel_set_ok = wel_set_req & ~wrsr_req & ~pe_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg         <= '0;
            wel         <= 1'b0;
            wrsr_reject <= 1'b0;
            pe_grant    <= 1'b0;
        end else begin
            wrsr_reject <= wr_bad;
            pe_grant    <= pe_req & wel & ~pe_hit;
            if (wr_ok) cfg <= cfg_from_byte(wrsr_data[STAT_W-1:0]);
            if (wel_clear)       wel <= 1'b0;
            else if (wel_set_ok) wel <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_prot_pkg::*;
#(
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_ARRAY_AW = ARRAY_AW,
    parameter int P_SECT_AW  = SECT_AW,
    parameter int P_STAT_W   = STAT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wp_n,
    input  logic                wel_set_req,
    input  logic                wrsr_req,
    input  logic [P_STAT_W-1:0] wrsr_data,
    input  logic                pe_req,
    input  logic [P_ADDR_W-1:0] pe_addr,
    output logic                addr_protected,
    output logic [P_STAT_W-1:0] status_rd,
    output logic                wrsr_reject,
    output logic                pe_grant
);
    prot_cfg_t cfg;
    logic      wel;
    logic      hit;

    prot_range_decode #(
        .P_ADDR_W   (P_ADDR_W),
        .P_ARRAY_AW (P_ARRAY_AW),
        .P_SECT_AW  (P_SECT_AW)
    ) u_range (
        .addr (pe_addr),
        .cfg  (cfg),
        .hit  (hit)
    );

    prot_status_ctrl #(
        .P_STAT_W (P_STAT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wp_n        (wp_n),
        .wel_set_req (wel_set_req),
        .wrsr_req    (wrsr_req),
        .wrsr_data   (wrsr_data),
        .pe_req      (pe_req),
        .pe_hit      (hit),
        .cfg         (cfg),
        .wel         (wel),
        .wrsr_reject (wrsr_reject),
        .pe_grant    (pe_grant)
    );

    always_comb begin
        addr_protected = hit;
        status_rd      = '0;
        status_rd[STAT_W-1:0] = byte_from_cfg(cfg, wel);
    end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       wrsr_req,
    input logic       pe_req,
    input logic [7:0] status_rd,
    input logic       addr_protected,
    input logic       wrsr_reject,
    input logic       pe_grant
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status_rd == 8'h00 && !wrsr_reject && !pe_grant));

    // R5
    a_r5_hw_lock_freeze: assert property (@(posedge clk) disable iff (rst)
        (status_rd[7] && !wp_n) |=> $stable(status_rd[7:2]));

    // R6
    a_r6_no_wel_reject: assert property (@(posedge clk) disable iff (rst)
        (wrsr_req && !status_rd[1]) |=> wrsr_reject);

    // R7
    a_r7_reject_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (wrsr_reject && !$past(pe_req)) |-> $stable(status_rd));

    // R11
    a_r11_grant_needs_wel: assert property (@(posedge clk) disable iff (rst)
        pe_grant |-> ($past(pe_req) && $past(status_rd[1]) && !$past(addr_protected)));

    // R11
    a_r11_pe_clears_wel: assert property (@(posedge clk) disable iff (rst)
        pe_req |=> !status_rd[1]);
endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wp_n           (wp_n),
    .wrsr_req       (wrsr_req),
    .pe_req         (pe_req),
    .status_rd      (status_rd),
    .addr_protected (addr_protected),
    .wrsr_reject    (wrsr_reject),
    .pe_grant       (pe_grant)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_n = 1'b1;
    logic        wel_set_req = 1'b0;
    logic        wrsr_req = 1'b0;
    logic [7:0]  wrsr_data = 8'h00;
    logic        pe_req = 1'b0;
    logic [23:0] pe_addr = 24'h0;
    logic        addr_protected;
    logic [7:0]  status_rd;
    logic        wrsr_reject;
    logic        pe_grant;

    always #10 clk = ~clk;

    flash_guard i_flash_guard (
        .clk(clk), .rst(rst), .wp_n(wp_n), .wel_set_req(wel_set_req),
        .wrsr_req(wrsr_req), .wrsr_data(wrsr_data), .pe_req(pe_req),
        .pe_addr(pe_addr), .addr_protected(addr_protected),
        .status_rd(status_rd), .wrsr_reject(wrsr_reject), .pe_grant(pe_grant)
    );

    typedef struct {
        logic [7:0] st;
        logic       rej;
        logic       gr;
        int         due;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // reference model state
    bit       m_lock = 0, m_anchor = 0, m_wel = 0;
    bit [2:0] m_guard = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit ref_hit(bit anchor, bit [2:0] code, logic [23:0] addr);
        longint len;
        longint a;
        len = (code == 0) ? 0 : (longint'(1) << (code - 1)) * 65536;
        a   = longint'(addr) & 64'h3FFFFF;
        if (anchor) return a < len;
        return a >= (64'd4194304 - len);
    endfunction

    function automatic logic [7:0] model_byte();
        return {m_lock, 1'b0, m_anchor, m_guard, m_wel, 1'b0};
    endfunction

    // monitor: pops expected items as they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (status_rd !== e.st || wrsr_reject !== e.rej || pe_grant !== e.gr) begin
                n_bad++;
                $display("FAIL %s: status=%h rej=%b grant=%b expected status=%h rej=%b grant=%b",
                         e.tag, status_rd, wrsr_reject, pe_grant, e.st, e.rej, e.gr);
            end
        end
    end

    task automatic check_comb(string tag);
        bit exp_h;
        exp_h = ref_hit(m_anchor, m_guard, pe_addr);
        n_vec++;
        if (addr_protected !== exp_h) begin
            n_bad++;
            $display("FAIL %s: addr=%h protected=%b expected %b", tag, pe_addr, addr_protected, exp_h);
        end
    endtask

    // driver: called at a negedge, drives one cycle, pushes expectation
    task automatic step(bit ws, bit wr, logic [7:0] d, bit pe, logic [23:0] a, bit wpn, string tag);
        bit   locked, ok, hitv, rej, gr;
        exp_t e;
        wel_set_req = ws; wrsr_req = wr; wrsr_data = d; pe_req = pe; pe_addr = a; wp_n = wpn;
        #1;
        check_comb({tag, " R10"});
        locked = m_lock & !wpn;
        ok     = wr & m_wel & !locked;
        rej    = wr & !ok;
        hitv   = ref_hit(m_anchor, m_guard, a);
        gr     = pe & m_wel & !hitv;
        if (ok) begin
            m_lock = d[7]; m_anchor = d[5]; m_guard = d[4:2];
        end
        if (ok | pe) m_wel = 0;
        else if (ws & !wr & !pe) m_wel = 1;
        e.st = model_byte(); e.rej = rej; e.gr = gr; e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        wel_set_req = 0; wrsr_req = 0; pe_req = 0;
    endtask

    task automatic probe(logic [23:0] a, string tag);
        pe_addr = a;
        #1;
        check_comb(tag);
        @(negedge clk);
    endtask

    function automatic logic [7:0] cfg_byte(bit lk, bit anc, bit [2:0] g);
        return {lk, 1'b0, anc, g, 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        n_vec++;
        if (status_rd !== 8'h00 || wrsr_reject !== 0 || pe_grant !== 0) begin
            n_bad++;
            $display("FAIL R1: status=%h rej=%b grant=%b expected 00 0 0", status_rd, wrsr_reject, pe_grant);
        end

        step(0, 1, 8'hBC, 0, 24'h0, 1, "R6 write without latch");
        step(1, 1, 8'hBC, 0, 24'h0, 1, "R3 set ignored with write");
        step(1, 0, 8'h00, 0, 24'h0, 1, "R3 latch set, R2 layout");
        step(1, 0, 8'h00, 1, 24'h3FFFFF, 1, "R3 set ignored with pe, R11");

        // sweep anchor and guard code
        for (int anc = 0; anc < 2; anc++) begin
            for (int g = 0; g < 8; g++) begin
                longint len, b;
                step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
                step(0, 1, cfg_byte(0, anc[0], g[2:0]), 0, 24'h0, 1, "R4 load config");
                len = (g == 0) ? 0 : (longint'(1) << (g - 1)) * 65536;
                b   = anc ? len : 64'd4194304 - len;
                probe(24'h000000, "R8 R9 low end");
                probe(24'h3FFFFF, "R8 R9 high end");
                probe(24'(b), "R9 boundary");
                if (b > 0) probe(24'(b - 1), "R9 boundary-1");
                probe(24'hC00000 | 24'(b), "R8 upper bits ignored");
                probe(24'h200000, "R8 midpoint");
                step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
                step(0, 0, 8'h00, 1, 24'h000000, 1, "R11 pe low end");
                step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
                step(0, 0, 8'h00, 1, 24'h3FFFFF, 1, "R11 pe high end");
            end
        end

        // hardware lock
        step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
        step(0, 1, cfg_byte(1, 0, 3'd3), 0, 24'h0, 1, "R4 set lock bit");
        step(1, 0, 8'h00, 0, 24'h0, 0, "R3 arm under lock");
        step(0, 1, 8'h00, 0, 24'h0, 0, "R5 R7 write refused under lock");
        step(0, 1, 8'h24, 0, 24'h0, 0, "R5 R7 anchor change refused");
        step(0, 1, 8'h00, 0, 24'h0, 1, "R12 pin high accepts write");
        step(1, 0, 8'h00, 0, 24'h0, 0, "R3 arm");
        step(0, 1, cfg_byte(1, 1, 3'd1), 0, 24'h0, 0, "R12 lock bit alone no lock");

        // same-cycle status write and program/erase
        step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
        step(0, 1, cfg_byte(0, 0, 3'd7), 0, 24'h0, 1, "R4 guard all");
        step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
        step(0, 1, cfg_byte(0, 0, 3'd0), 1, 24'h000100, 1, "R13 old guard blocks");
        step(1, 0, 8'h00, 0, 24'h0, 1, "R3 arm");
        step(0, 1, cfg_byte(0, 1, 3'd7), 1, 24'h000100, 1, "R13 old open grants");
        step(0, 0, 8'h00, 0, 24'h0, 1, "R7 idle after");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule